// File: doc/BRIEF.md
# Read-to-Acquire Channel Semaphore

This block is a single memory-mapped lock register that decides who may drive one shared auxiliary channel. Two agents want the channel: software on a simple host bus, and an autonomous hardware engine (a self-refresh controller, for example) that starts its own channel traffic. Software takes the lock by reading the register. A status value of 0 in the returned word means the read has just won the lock. A value of 1 means the lock is already held, and software keeps reading until it sees 0. Software frees the lock by writing the status bit as 1 with the enable bit also set.

The hardware engine uses a request/grant/release handshake. A request made while the lock is free is granted on the next cycle. The grant stays up until the engine sends a one-cycle release pulse. If the lock is free and a host read arrives in the same cycle as a hardware request, the hardware engine wins. While the mutex is disabled, host reads only report the register and never take the lock. The hardware engine still gets the channel whenever it is free. A reset, such as the one applied on deep power-state entry, clears the enable bit and all ownership.

Top module: `aux_sem_reg`

## Requirements
- R1: After reset the enable bit is 0, nobody owns the lock (owner_valid=0, owner_is_hw=0, hw_grant=0) and host_rdata is 0.
- R2: The register answers only at address REG_ADDR. Bit 31 holds the enable value and bit 30 the status, and all other bits read as 0. Read data appears the cycle after the read strobe, and host_rdata is 0 in any cycle that follows no matching read. A read at another address returns 0 and changes no state.
- R3: A matching read, made while the mutex is enabled, the lock is free and there is no hardware request, returns status 0. On the same edge that registers the read data, the owner becomes the host.
- R4: A matching read made while the lock is held by either agent returns status 1 and leaves the owner unchanged.
- R5: If the lock is free and enabled, and a matching host read coincides with hw_req, the hardware engine gets the grant and the read returns status 1.
- R6: hw_req while the lock is free raises hw_grant one cycle later. hw_grant stays high until a hw_release pulse, and the lock is free in the cycle after that pulse.
- R7: hw_release while the hardware engine does not own the lock has no effect.
- R8: A write with both bit 31 and bit 30 set, made while the host owns the lock, frees the lock and leaves the mutex enabled. A write with bit 30 clear, or with bit 31 clear, does not free the lock. The enable bit always takes the value of bit 31.
- R9: While the hardware engine owns the lock, host writes change neither hw_grant nor owner_is_hw, whatever they do to the enable bit.
- R10: While the mutex is disabled, host reads never take the lock. hw_req is still granted when the lock is free.
- R11: If read and write strobes arrive together, only the write is performed. The read has no side effect and host_rdata reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register and all ownership |
| host_rd | input | 1 | Host read strobe (a lock attempt when enabled) |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| hw_req | input | 1 | Hardware engine lock request |
| hw_release | input | 1 | One-cycle release pulse from the hardware engine |
| hw_grant | output | 1 | Lock granted to the hardware engine |
| owner_valid | output | 1 | Registered: the lock is held by some agent |
| owner_is_hw | output | 1 | Registered: the holder is the hardware engine |

## Verification
The bench builds the block with a 4-bit address and the register placed at address 5 rather than 0. This lets it show that reads at a neighbouring address have no locking side effect, and that write data bits outside bits 31 and 30 are ignored. The 32-bit word and the default field positions are kept, so every expected read value is one of four fixed words. These defaults make the same-cycle tie, non-owner release and enable-write-during-hardware-ownership cases reachable in a few directed cycles each.

// File: rtl/aux_sem_pkg.sv
package aux_sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_HW   = 2'd2
  } owner_e;
endpackage

// File: rtl/aux_sem_decode.sv
module aux_sem_decode #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wd_en,
  input  logic              wd_st,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              release_req
);
  logic sel;
  assign sel         = (addr == REG_ADDR);
  // a write in the same cycle suppresses the read and its side effect
  assign rd_hit      = sel && rd && !wr;
  assign wr_hit      = sel && wr;
  assign release_req = wr_hit && wd_en && wd_st;
endmodule

// File: rtl/aux_sem_arbiter.sv
module aux_sem_arbiter
  import aux_sem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_q,
  input  logic   rd_hit,
  input  logic   release_req,
  input  logic   hw_req,
  input  logic   hw_release,
  output owner_e owner_q,
  output logic   rd_status,
  output logic   host_take,
  output logic   hw_take
);
  owner_e owner_d;
  logic   free;

  assign free      = (owner_q == OWN_NONE);
  // hardware wins any same-cycle contention for a free lock
  assign hw_take   = free && hw_req;
  assign host_take = free && en_q && rd_hit && !hw_req;
  assign rd_status = !free || hw_req;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (hw_take)        owner_d = OWN_HW;
        else if (host_take) owner_d = OWN_HOST;
      end
      OWN_HOST: if (release_req) owner_d = OWN_NONE;
      OWN_HW:   if (hw_release)  owner_d = OWN_NONE;
      default:  owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end
endmodule

// File: rtl/aux_sem_reg.sv
module aux_sem_reg
  import aux_sem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int EN_BIT = 31,
  parameter int ST_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              hw_req,
  input  logic              hw_release,
  output logic              hw_grant,
  output logic              owner_valid,
  output logic              owner_is_hw
);
  function automatic logic [DATA_W-1:0] pack_word(input logic en, input logic st);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT] = en;
    w[ST_BIT] = st;
    return w;
  endfunction

  logic   en_q, rd_hit, wr_hit, release_req;
  logic   rd_status, host_take, hw_take;
  owner_e owner_q;
  logic [DATA_W-1:0] rdata_q;

  aux_sem_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .rd(host_rd), .wr(host_wr), .addr(host_addr),
    .wd_en(host_wdata[EN_BIT]), .wd_st(host_wdata[ST_BIT]),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .release_req(release_req)
  );

  aux_sem_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .rd_hit(rd_hit),
    .release_req(release_req), .hw_req(hw_req), .hw_release(hw_release),
    .owner_q(owner_q), .rd_status(rd_status),
    .host_take(host_take), .hw_take(hw_take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_hit) en_q <= host_wdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_hit) rdata_q <= pack_word(en_q, rd_status);
    else             rdata_q <= '0;
  end

  assign host_rdata  = rdata_q;
  assign hw_grant    = (owner_q == OWN_HW);
  assign owner_valid = (owner_q != OWN_NONE);
  assign owner_is_hw = (owner_q == OWN_HW);
endmodule

// File: rtl/aux_sem_checker.sv
module aux_sem_checker (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic rd_hit,
  input logic wr_hit,
  input logic hw_req,
  input logic hw_release,
  input logic hw_grant,
  input logic owner_valid,
  input logic owner_is_hw,
  input logic rd_st
);
  p_host_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && rd_hit && !owner_valid && !hw_req |=> owner_valid && !owner_is_hw && !rd_st);

  p_busy_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && owner_valid |=> rd_st);

  p_tie_hw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && rd_hit && !owner_valid && hw_req |=> owner_is_hw && rd_st);

  p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_grant && !hw_release |=> hw_grant);

  p_nonowner_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    owner_valid && !owner_is_hw && hw_release && !wr_hit |=> owner_valid && !owner_is_hw);

  p_hw_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    owner_is_hw && wr_hit && !hw_release |=> owner_is_hw && hw_grant);

  p_quiet_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && rd_hit && !hw_req && !hw_release && !wr_hit |=> $stable(owner_valid));
endmodule

bind aux_sem_reg aux_sem_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .rd_hit(rd_hit), .wr_hit(wr_hit),
  .hw_req(hw_req), .hw_release(hw_release), .hw_grant(hw_grant),
  .owner_valid(owner_valid), .owner_is_hw(owner_is_hw),
  .rd_st(host_rdata[ST_BIT])
);

// File: tb/aux_sem_reg_bench.sv
module aux_sem_reg_bench;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] RA = 4'h5;
  localparam logic [DW-1:0] W_EN    = 32'h8000_0000;
  localparam logic [DW-1:0] W_EN_ST = 32'hC000_0000;
  localparam logic [DW-1:0] W_ST    = 32'h4000_0000;

  logic clk = 0, rst_n = 0;
  logic host_rd = 0, host_wr = 0, hw_req = 0, hw_release = 0;
  logic [AW-1:0] host_addr = RA;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic hw_grant, owner_valid, owner_is_hw;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  aux_sem_reg #(.DATA_W(DW), .ADDR_W(AW), .REG_ADDR(RA)) u_aux_sem_reg (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .hw_req(hw_req), .hw_release(hw_release), .hw_grant(hw_grant),
    .owner_valid(owner_valid), .owner_is_hw(owner_is_hw)
  );

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // owner code used by the bench: 0 none, 1 host, 2 hardware
  task automatic chk_owner(input string tag, input int exp);
    logic [1:0] act;
    act = {owner_is_hw, owner_valid && !owner_is_hw};
    chk(act == exp[1:0] && hw_grant == owner_is_hw, tag, {30'b0, act}, exp);
  endtask

  // one bus cycle: drive at negedge, release at next negedge (outputs then updated)
  task automatic cyc(input logic rd, input logic wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic rq, input logic rl);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
    hw_req = rq; hw_release = rl;
    @(negedge clk);
    host_rd = 0; host_wr = 0; host_addr = RA; host_wdata = '0;
    hw_req = 0; hw_release = 0;
  endtask

  task automatic t_reset();
    chk(host_rdata == '0, "R1 rdata", host_rdata, '0);
    chk_owner("R1 owner", 0);
    cyc(1, 0, RA, '0, 0, 0);
    chk(host_rdata == '0, "R1 enable low", host_rdata, '0);
    chk_owner("R10 disabled read no lock", 0);
  endtask

  task automatic t_host();
    cyc(0, 1, RA, W_EN | 32'h0000_00FF, 0, 0);
    cyc(1, 0, RA + 4'd1, '0, 0, 0);
    chk(host_rdata == '0, "R2 other address", host_rdata, '0);
    chk_owner("R2 other address no lock", 0);
    cyc(1, 0, RA, '0, 0, 0);
    chk(host_rdata == W_EN, "R3 acquire status 0", host_rdata, W_EN);
    chk_owner("R3 host owner", 1);
    @(negedge clk);
    chk(host_rdata == '0, "R2 idle rdata", host_rdata, '0);
    cyc(1, 0, RA, '0, 0, 0);
    chk(host_rdata == W_EN_ST, "R4 reread busy", host_rdata, W_EN_ST);
    chk_owner("R4 owner kept", 1);
    cyc(0, 1, RA, W_ST, 0, 0);
    chk_owner("R8 status without enable keeps lock", 1);
    cyc(0, 1, RA, W_EN, 0, 0);
    chk_owner("R8 enable only keeps lock", 1);
    cyc(0, 1, RA, W_EN_ST, 0, 0);
    chk_owner("R8 release", 0);
    cyc(1, 0, RA, '0, 0, 0);
    chk(host_rdata == W_EN, "R8 stays enabled", host_rdata, W_EN);
    cyc(0, 1, RA, W_EN_ST, 0, 0);
    chk_owner("R8 released again", 0);
  endtask

  task automatic t_hw();
    cyc(0, 0, RA, '0, 1, 0);
    chk_owner("R6 grant", 2);
    repeat (3) @(negedge clk);
    chk_owner("R6 grant held", 2);
    cyc(1, 0, RA, '0, 0, 0);
    chk(host_rdata == W_EN_ST, "R4 busy by hw", host_rdata, W_EN_ST);
    cyc(0, 1, RA, W_EN_ST, 0, 0);
    chk_owner("R9 host release ignored", 2);
    cyc(0, 1, RA, '0, 0, 0);
    chk_owner("R9 disable keeps hw", 2);
    cyc(0, 1, RA, W_EN, 0, 0);
    chk_owner("R9 enable keeps hw", 2);
    cyc(0, 0, RA, '0, 0, 1);
    chk_owner("R6 released", 0);
  endtask

  task automatic t_tie();
    cyc(1, 0, RA, '0, 1, 0);
    chk(host_rdata == W_EN_ST, "R5 read sees busy", host_rdata, W_EN_ST);
    chk_owner("R5 hw wins", 2);
    cyc(0, 0, RA, '0, 0, 1);
  endtask

  task automatic t_nonowner();
    cyc(0, 0, RA, '0, 0, 1);
    chk_owner("R7 release while free", 0);
    cyc(1, 0, RA, '0, 0, 0);
    cyc(0, 0, RA, '0, 0, 1);
    chk_owner("R7 hw release vs host owner", 1);
    cyc(0, 1, RA, W_EN_ST, 0, 0);
  endtask

  task automatic t_rdwr();
    cyc(1, 1, RA, W_EN, 0, 0);
    chk(host_rdata == '0, "R11 read dropped", host_rdata, '0);
    chk_owner("R11 no lock", 0);
  endtask

  task automatic t_disabled();
    cyc(0, 1, RA, '0, 0, 0);
    cyc(1, 0, RA, '0, 0, 0);
    chk(host_rdata == '0, "R10 read disabled", host_rdata, '0);
    chk_owner("R10 no host lock", 0);
    cyc(0, 0, RA, '0, 1, 0);
    chk_owner("R10 hw granted while disabled", 2);
    cyc(1, 0, RA, '0, 0, 0);
    chk(host_rdata == W_ST, "R10 status shows hw", host_rdata, W_ST);
    cyc(0, 0, RA, '0, 0, 1);
    chk_owner("R10 hw released", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_host();
    t_hw();
    t_tie();
    t_nonowner();
    t_rdwr();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule